// File: doc/BRIEF.md
# Flash Command Sequencer

This block is the command front end of a byte-wide flash device. A host writes command bytes over a parallel bus that has an active-low write strobe. The block decodes those writes into single-write commands and two-write armed sequences. It selects what a read returns: array data, identifier codes, erase-verify data, or operation status. When a sequence is complete, it starts an internal program/erase engine and hands it a latched address, a data byte and an operation kind.

The write strobe is oversampled by the system clock. The address is taken when the strobe falls and the data when it rises. The sequence is acted on after the rising edge. A programming-voltage-present input gates every alteration. While that voltage is absent, the block sits in array read mode and ignores writes. While the engine runs, the block reports status and ignores commands, with one exception: two consecutive FFh writes abort the engine.

Top module: `flash_cmd_seq`

## Requirements
- R1: While `vpp_ok` is low, `rd_mode` is array read (0), `op_start` stays low and host writes have no effect. Dropping `vpp_ok` returns any mode to array read.
- R2: After reset, and after a write of 00h, `rd_mode` is array read (0). It stays there until another command is written.
- R3: A write of 90h selects identifier mode (`rd_mode` = 1). In that mode `id_code` is C2h for read address 0, 1Ah for address 1 and 00h for any other address. Outside identifier mode `id_code` is 00h.
- R4: A write of 40h followed by a second write starts a program (`op_kind` = 1). The start carries the address and data of the second write, unless that data is FFh.
- R5: 30h then 30h starts an automatic chip erase (`op_kind` = 2). 20h then D0h starts an automatic block erase (`op_kind` = 3). In both cases `op_addr` is the address of the second write.
- R6: 20h then 20h starts a chip erase (`op_kind` = 4). 60h then 60h starts a block erase (`op_kind` = 5), and `op_addr` is the address of the second write.
- R7: A write of A0h selects erase-verify mode (`rd_mode` = 2). `vfy_addr` takes the address of that write.
- R8: A setup write followed by a write that matches no valid completion returns to array read mode and starts nothing.
- R9: `op_start` is a single-cycle pulse. From that cycle, `rd_mode` is status (3) until `eng_done` is seen, and then it is array read.
- R10: While an operation runs, writes other than the FFh pair start nothing and leave `rd_mode` at status.
- R11: Two consecutive FFh writes during a running operation give one `op_abort` pulse and array read mode. An FFh pair after a setup write starts nothing.
- R12: The address is captured when `we_n` falls and the data when it rises. Address changes after the fall, and data changes before the rise, do not affect the captured values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| vpp_ok | input | 1 | Programming voltage present |
| we_n | input | 1 | Active-low host write strobe |
| addr | input | 17 | Host address, used for both reads and writes |
| din | input | 8 | Host write data |
| eng_done | input | 1 | Engine finished the running operation |
| rd_mode | output | 2 | Read source: 0 array, 1 identifier, 2 verify, 3 status |
| id_code | output | 8 | Identifier byte for the current address |
| vfy_addr | output | 17 | Address latched by the erase-verify command |
| op_start | output | 1 | One-cycle engine start pulse |
| op_kind | output | 3 | Operation kind for the engine |
| op_addr | output | 17 | Target address for the engine |
| op_data | output | 8 | Program data for the engine |
| op_abort | output | 1 | One-cycle engine abort pulse |

## Verification
A corrupted sequencer state appears on `rd_mode` within one clock after the write that should have updated it. A lost or extra arming state shows as a missing or unexpected `op_start` about three clocks after the rising edge of the second strobe. The scoreboard matches every start pulse against an expected kind, address and data. Any start that was not announced fails at once, including a pulse wider than one cycle. Capture-edge mistakes show up as the wrong `op_addr` or `op_data` in the split-write case, where address and data change while the strobe is low.

// File: rtl/flash_cmd_pkg.sv
// Shared command codes, read-mode and operation encodings for the flash
// command sequencer. Assumes byte-wide command data.
package flash_cmd_pkg;

    localparam int CMD_W = 8;

    localparam logic [CMD_W-1:0] CMD_READ     = 8'h00;
    localparam logic [CMD_W-1:0] CMD_IDENT    = 8'h90;
    localparam logic [CMD_W-1:0] CMD_AUTO_CE  = 8'h30;
    localparam logic [CMD_W-1:0] CMD_SETUP_20 = 8'h20;
    localparam logic [CMD_W-1:0] CMD_AUTO_BE  = 8'hD0;
    localparam logic [CMD_W-1:0] CMD_PROG     = 8'h40;
    localparam logic [CMD_W-1:0] CMD_BLK_ER   = 8'h60;
    localparam logic [CMD_W-1:0] CMD_VERIFY   = 8'hA0;
    localparam logic [CMD_W-1:0] CMD_RESET    = 8'hFF;

    typedef enum logic [1:0] {
        RM_ARRAY  = 2'd0,
        RM_IDENT  = 2'd1,
        RM_VERIFY = 2'd2,
        RM_STATUS = 2'd3
    } rd_mode_e;

    typedef enum logic [2:0] {
        OK_NONE      = 3'd0,
        OK_PROGRAM   = 3'd1,
        OK_AUTO_CHIP = 3'd2,
        OK_AUTO_BLK  = 3'd3,
        OK_CHIP      = 3'd4,
        OK_BLK       = 3'd5
    } op_kind_e;

    typedef enum logic [2:0] {
        ST_READ,
        ST_IDENT,
        ST_VERIFY,
        ST_SET_ACE,
        ST_SET_20,
        ST_SET_PROG,
        ST_SET_BLK,
        ST_RUN
    } seq_state_e;

endpackage

// File: rtl/fc_strobe_sync.sv
// Oversamples the asynchronous write strobe with the system clock. Captures
// the address at the detected falling edge and the data at the detected rising
// edge, then issues a one-cycle write event carrying both.
// Assumes each strobe phase lasts at least three clock cycles, and that
// addr/din hold steady for two clocks around each edge.
module fc_strobe_sync #(
    parameter int AW    = 17,
    parameter int DW    = 8,
    parameter int SYNC  = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we_n,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] din,
    output logic          wr_fire,
    output logic [AW-1:0] wr_addr,
    output logic [DW-1:0] wr_data
);
    localparam int LAST = SYNC - 1;

    logic [SYNC-1:0] we_sh;
    logic            we_prev;
    logic            fall_ev;
    logic            rise_ev;

    // Shift the strobe through the synchroniser chain.
    always_ff @(posedge clk) begin
        if (!rst_n) we_sh <= '1;
        else        we_sh <= {we_sh[SYNC-2:0], we_n};
    end

    // Hold the previous synchronised level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) we_prev <= 1'b1;
        else        we_prev <= we_sh[LAST];
    end

    assign fall_ev = we_prev & ~we_sh[LAST];
    assign rise_ev = ~we_prev & we_sh[LAST];

    // Capture the address at the fall and the data plus the event at the rise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_addr <= '0;
            wr_data <= '0;
            wr_fire <= 1'b0;
        end else begin
            wr_fire <= rise_ev;
            if (fall_ev) wr_addr <= addr;
            if (rise_ev) wr_data <= din;
        end
    end

    a_r12_fire_single: assert property (@(posedge clk) disable iff (!rst_n)
        wr_fire |=> !wr_fire);

    a_r12_addr_held: assert property (@(posedge clk) disable iff (!rst_n)
        !fall_ev |=> $stable(wr_addr));

endmodule

// File: rtl/fc_cmd_fsm.sv
// Command decoder and sequence state machine. Turns write events into mode
// changes, engine start pulses and abort pulses. Applies the programming-
// voltage lock and the busy lockout. Assumes eng_done only matters while an
// operation runs.
module fc_cmd_fsm
    import flash_cmd_pkg::*;
#(
    parameter int AW = 17
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             vpp_ok,
    input  logic             wr_fire,
    input  logic [AW-1:0]    wr_addr,
    input  logic [CMD_W-1:0] wr_data,
    input  logic             eng_done,
    output rd_mode_e         rd_mode,
    output logic [AW-1:0]    vfy_addr,
    output logic             op_start,
    output op_kind_e         op_kind,
    output logic [AW-1:0]    op_addr,
    output logic [CMD_W-1:0] op_data,
    output logic             op_abort
);
    seq_state_e st;
    logic       ff_prev;
    op_kind_e   arm_kind;
    logic       arm_ok;

    // Decide whether the second write completes the armed setup.
    always_comb begin
        arm_kind = OK_NONE;
        unique case (st)
            ST_SET_ACE:  if (wr_data == CMD_AUTO_CE)  arm_kind = OK_AUTO_CHIP;
            ST_SET_20: begin
                if (wr_data == CMD_AUTO_BE)       arm_kind = OK_AUTO_BLK;
                else if (wr_data == CMD_SETUP_20) arm_kind = OK_CHIP;
            end
            ST_SET_PROG: if (wr_data != CMD_RESET)    arm_kind = OK_PROGRAM;
            ST_SET_BLK:  if (wr_data == CMD_BLK_ER)   arm_kind = OK_BLK;
            default:     arm_kind = OK_NONE;
        endcase
        arm_ok = (arm_kind != OK_NONE);
    end

    // Sequence register: lock, run/abort handling and command decode.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st       <= ST_READ;
            ff_prev  <= 1'b0;
            op_start <= 1'b0;
            op_abort <= 1'b0;
            op_kind  <= OK_NONE;
            op_addr  <= '0;
            op_data  <= '0;
            vfy_addr <= '0;
        end else begin
            op_start <= 1'b0;
            op_abort <= 1'b0;
            if (!vpp_ok) begin
                st      <= ST_READ;
                ff_prev <= 1'b0;
            end else if (st == ST_RUN) begin
                if (eng_done) begin
                    st      <= ST_READ;
                    ff_prev <= 1'b0;
                end else if (wr_fire) begin
                    ff_prev <= (wr_data == CMD_RESET);
                    if (ff_prev && wr_data == CMD_RESET) begin
                        op_abort <= 1'b1;
                        st       <= ST_READ;
                    end
                end
            end else if (wr_fire) begin
                ff_prev <= (wr_data == CMD_RESET);
                if (st == ST_SET_ACE || st == ST_SET_20 ||
                    st == ST_SET_PROG || st == ST_SET_BLK) begin
                    if (arm_ok) begin
                        st       <= ST_RUN;
                        op_start <= 1'b1;
                        op_kind  <= arm_kind;
                        op_addr  <= wr_addr;
                        op_data  <= wr_data;
                    end else begin
                        st <= ST_READ;
                    end
                end else begin
                    unique case (wr_data)
                        CMD_IDENT:    st <= ST_IDENT;
                        CMD_VERIFY: begin
                            st       <= ST_VERIFY;
                            vfy_addr <= wr_addr;
                        end
                        CMD_AUTO_CE:  st <= ST_SET_ACE;
                        CMD_SETUP_20: st <= ST_SET_20;
                        CMD_PROG:     st <= ST_SET_PROG;
                        CMD_BLK_ER:   st <= ST_SET_BLK;
                        default:      st <= ST_READ;
                    endcase
                end
            end
        end
    end

    // Map the sequence state onto the read source.
    always_comb begin
        unique case (st)
            ST_IDENT:  rd_mode = RM_IDENT;
            ST_VERIFY: rd_mode = RM_VERIFY;
            ST_RUN:    rd_mode = RM_STATUS;
            default:   rd_mode = RM_ARRAY;
        endcase
    end

    a_r1_locked: assert property (@(posedge clk) disable iff (!rst_n)
        !vpp_ok |=> (!op_start && rd_mode == RM_ARRAY));

    a_r9_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        op_start |=> !op_start);

    a_r9_status: assert property (@(posedge clk) disable iff (!rst_n)
        op_start |-> rd_mode == RM_STATUS);

    a_r10_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
        rd_mode == RM_STATUS |=> !op_start);

    a_r11_abort_from_run: assert property (@(posedge clk) disable iff (!rst_n)
        op_abort |-> $past(st) == ST_RUN);

endmodule

// File: rtl/fc_read_sel.sv
// Identifier byte generator for the read path. Returns the maker and device
// codes at addresses 0 and 1 in identifier mode, and zero everywhere else.
// Assumes the read address comes in on the shared host address bus.
module fc_read_sel
    import flash_cmd_pkg::*;
#(
    parameter int               AW     = 17,
    parameter logic [CMD_W-1:0] MFR_ID = 8'hC2,
    parameter logic [CMD_W-1:0] DEV_ID = 8'h1A
) (
    input  rd_mode_e         rd_mode,
    input  logic [AW-1:0]    addr,
    output logic [CMD_W-1:0] id_code
);
    // Pick the identifier byte from the low address.
    always_comb begin
        id_code = '0;
        if (rd_mode == RM_IDENT) begin
            if (addr == AW'(0))      id_code = MFR_ID;
            else if (addr == AW'(1)) id_code = DEV_ID;
        end
    end

endmodule

// File: rtl/flash_cmd_seq.sv
// Top of the flash command sequencer: strobe capture, command state machine
// and identifier read path. Assumes a single clock domain, with we_n
// oversampled and not used as a clock.
module flash_cmd_seq
    import flash_cmd_pkg::*;
#(
    parameter int AW = 17
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          vpp_ok,
    input  logic          we_n,
    input  logic [AW-1:0] addr,
    input  logic [7:0]    din,
    input  logic          eng_done,
    output logic [1:0]    rd_mode,
    output logic [7:0]    id_code,
    output logic [AW-1:0] vfy_addr,
    output logic          op_start,
    output logic [2:0]    op_kind,
    output logic [AW-1:0] op_addr,
    output logic [7:0]    op_data,
    output logic          op_abort
);
    logic             wr_fire;
    logic [AW-1:0]    wr_addr;
    logic [CMD_W-1:0] wr_data;
    rd_mode_e         mode_q;
    op_kind_e         kind_q;

    fc_strobe_sync #(.AW(AW), .DW(CMD_W), .SYNC(2)) i_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_n    (we_n),
        .addr    (addr),
        .din     (din),
        .wr_fire (wr_fire),
        .wr_addr (wr_addr),
        .wr_data (wr_data)
    );

    fc_cmd_fsm #(.AW(AW)) i_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .vpp_ok   (vpp_ok),
        .wr_fire  (wr_fire),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .eng_done (eng_done),
        .rd_mode  (mode_q),
        .vfy_addr (vfy_addr),
        .op_start (op_start),
        .op_kind  (kind_q),
        .op_addr  (op_addr),
        .op_data  (op_data),
        .op_abort (op_abort)
    );

    fc_read_sel #(.AW(AW)) i_rsel (
        .rd_mode (mode_q),
        .addr    (addr),
        .id_code (id_code)
    );

    assign rd_mode = mode_q;
    assign op_kind = kind_q;

endmodule

// File: tb/test_flash_cmd_seq.sv
// Scoreboard bench: the driver pushes expected engine starts into a queue,
// and a monitor pops and compares them on each op_start pulse.
module test_flash_cmd_seq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        vpp_ok = 1'b1;
    logic        we_n = 1'b1;
    logic [16:0] addr = '0;
    logic [7:0]  din = '0;
    logic        eng_done = 1'b0;
    logic [1:0]  rd_mode;
    logic [7:0]  id_code;
    logic [16:0] vfy_addr;
    logic        op_start;
    logic [2:0]  op_kind;
    logic [16:0] op_addr;
    logic [7:0]  op_data;
    logic        op_abort;

    int total = 0;
    int bad = 0;
    int aborts = 0;
    logic [27:0] expq[$];
    bit finished = 0;

    always #5 clk = ~clk;

    flash_cmd_seq i_flash_cmd_seq (
        .clk(clk), .rst_n(rst_n), .vpp_ok(vpp_ok), .we_n(we_n), .addr(addr),
        .din(din), .eng_done(eng_done), .rd_mode(rd_mode), .id_code(id_code),
        .vfy_addr(vfy_addr), .op_start(op_start), .op_kind(op_kind),
        .op_addr(op_addr), .op_data(op_data), .op_abort(op_abort)
    );

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(logic [16:0] a, logic [7:0] d);
        @(negedge clk);
        addr = a; din = d; we_n = 1'b0;
        repeat (4) @(negedge clk);
        we_n = 1'b1;
        repeat (5) @(negedge clk);
    endtask

    // Address moves after the fall, data moves before the rise.
    task automatic wr_split(logic [16:0] a0, logic [16:0] a1,
                            logic [7:0] d0, logic [7:0] d1);
        @(negedge clk);
        addr = a0; din = d0; we_n = 1'b0;
        repeat (4) @(negedge clk);
        addr = a1; din = d1;
        repeat (3) @(negedge clk);
        we_n = 1'b1;
        repeat (5) @(negedge clk);
    endtask

    task automatic expect_start(logic [2:0] k, logic [16:0] a, logic [7:0] d);
        expq.push_back({k, a, d});
    endtask

    task automatic done_pulse();
        @(negedge clk); eng_done = 1'b1;
        @(negedge clk); eng_done = 1'b0;
        @(negedge clk);
    endtask

    // Monitor: every start pulse cycle must match the next expected item (R9).
    always @(negedge clk) begin
        if (rst_n && op_start) begin
            if (expq.size() == 0) chk("R9 unexpected start", {29'd0, op_kind}, 32'd0);
            else begin
                logic [27:0] e;
                e = expq.pop_front();
                chk("R4/R5/R6 start kind", {29'd0, op_kind}, {29'd0, e[27:25]});
                chk("R4/R5/R6/R12 start addr", {15'd0, op_addr}, {15'd0, e[24:8]});
                chk("R4/R12 start data", {24'd0, op_data}, {24'd0, e[7:0]});
            end
        end
        if (rst_n && op_abort) aborts++;
    end

    initial begin
        #(10 * 150000);
        chk("watchdog", 32'd0, 32'd1);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R2 reset mode", rd_mode, 0);
        chk("R9 reset start", op_start, 0);
        chk("R3 id quiet in array", id_code, 0);

        // R3 identifier reads
        wr(17'h0, 8'h90);
        chk("R3 mode", rd_mode, 1);
        addr = 17'h0; @(negedge clk);
        chk("R3 maker code", id_code, 8'hC2);
        addr = 17'h1; @(negedge clk);
        chk("R3 device code", id_code, 8'h1A);
        addr = 17'h5; @(negedge clk);
        chk("R3 other addr", id_code, 8'h00);

        // R2 back to array read
        wr(17'h0, 8'h00);
        chk("R2 array", rd_mode, 0);
        addr = 17'h0; @(negedge clk);
        chk("R3 id quiet after exit", id_code, 0);

        // R7 erase verify
        wr(17'h1234, 8'hA0);
        chk("R7 mode", rd_mode, 2);
        chk("R7 address", vfy_addr, 17'h1234);

        // R4 program, R9 status then done
        wr(17'h0, 8'h40);
        expect_start(3'd1, 17'h0ABCD, 8'h5A);
        wr(17'h0ABCD, 8'h5A);
        chk("R9 status", rd_mode, 3);
        done_pulse();
        chk("R9 after done", rd_mode, 0);

        // R10 writes while busy, then R11 abort
        wr(17'h0, 8'h40);
        expect_start(3'd1, 17'h00100, 8'h11);
        wr(17'h00100, 8'h11);
        wr(17'h0, 8'h00);
        chk("R10 mode held", rd_mode, 3);
        wr(17'h0, 8'h40);
        wr(17'h5, 8'h77);
        chk("R10 still status", rd_mode, 3);
        wr(17'h0, 8'hFF);
        chk("R11 single FF no abort", aborts, 0);
        wr(17'h0, 8'hFF);
        chk("R11 abort pulse", aborts, 1);
        chk("R11 array after abort", rd_mode, 0);

        // R5 automatic erases
        wr(17'h0, 8'h30);
        expect_start(3'd2, 17'h00042, 8'h30);
        wr(17'h00042, 8'h30);
        done_pulse();
        wr(17'h0, 8'h20);
        expect_start(3'd3, 17'h1C000, 8'hD0);
        wr(17'h1C000, 8'hD0);
        done_pulse();

        // R6 plain erases
        wr(17'h0, 8'h20);
        expect_start(3'd4, 17'h00007, 8'h20);
        wr(17'h00007, 8'h20);
        done_pulse();
        wr(17'h0, 8'h60);
        expect_start(3'd5, 17'h08000, 8'h60);
        wr(17'h08000, 8'h60);
        done_pulse();
        chk("R6 queue drained", expq.size(), 0);

        // R8 mismatched completions
        wr(17'h0, 8'h30);
        wr(17'h0, 8'h20);
        chk("R8 mismatch to array", rd_mode, 0);
        wr(17'h0, 8'h60);
        wr(17'h0, 8'h00);
        chk("R8 mismatch blk", rd_mode, 0);

        // R11 FF pair after setup starts nothing
        wr(17'h0, 8'h20);
        wr(17'h0, 8'hFF);
        wr(17'h0, 8'hFF);
        chk("R11 setup abort mode", rd_mode, 0);
        chk("R11 setup abort no pulse", aborts, 1);

        // R1 programming voltage absent
        vpp_ok = 1'b0;
        wr(17'h0, 8'h90);
        chk("R1 id ignored", rd_mode, 0);
        wr(17'h0, 8'h30);
        wr(17'h0, 8'h30);
        chk("R1 erase ignored", rd_mode, 0);
        vpp_ok = 1'b1;
        wr(17'h0, 8'h90);
        chk("R1 id with vpp", rd_mode, 1);
        vpp_ok = 1'b0;
        repeat (2) @(negedge clk);
        chk("R1 vpp drop to array", rd_mode, 0);
        vpp_ok = 1'b1;

        // R12 capture edges
        wr(17'h0, 8'h40);
        expect_start(3'd1, 17'h11111, 8'h44);
        wr_split(17'h11111, 17'h02222, 8'h33, 8'h44);
        done_pulse();

        repeat (4) @(negedge clk);
        chk("R9 all starts seen", expq.size(), 0);
        chk("R11 total aborts", aborts, 1);
        if (!finished) begin
            finished = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule